// File: doc/BRIEF.md
# Serial DAC Write-Port Receiver

This block is the digital front end of a 16-bit voltage-output DAC. A host writes it over a three-wire, write-only serial link. The link has a serial clock, an active-low frame select and a data line. The host shifts in 24-bit words, most significant bit first, and the block samples the data line on each falling serial-clock edge while the frame select is low. The three link inputs are asynchronous to the block's system clock. They pass through synchronizers, and the block detects their edges in the system clock domain.

A word takes effect only when all 24 falling edges arrive inside one select window. A word cut short by an early rise of the select line is thrown away. Each accepted word carries a two-bit power-down field and a 16-bit code. A word in normal mode loads the code. A word in a power-down mode changes only the output termination and leaves the stored code alone. The power-down mode drives three control strobes for the analog output stage: amplifier enable, 1k pull-down and 100k pull-down. A parameter sets the power-on code, either zero or midscale.

Top module: `sdac_rx`

## Requirements
- R1: A word is 24 bits, shifted in MSB first. Word bits 15:0 form the code presented on `dac_code_o` after a normal-mode commit.
- R2: A word commits only on the 24th falling SCLK edge within one SYNC-low window. Each commit gives exactly one single-cycle `updated_o` pulse.
- R3: If SYNC rises before the 24th falling edge, the code and the mode stay unchanged and no `updated_o` pulse occurs.
- R4: Word bits 17:16 select the mode. 00 gives `out_en_o`=1. 01 gives `pd_1k_o`=1. 10 gives `pd_100k_o`=1. 11 drives all three low (high impedance).
- R5: `out_en_o` is high only in mode 00, and at most one of the three strobes is high in any cycle.
- R6: A committed word with a nonzero mode field leaves `dac_code_o` unchanged.
- R7: After reset, `dac_code_o` equals parameter `RESET_CODE` and the mode is 00. Both hold until the first commit.
- R8: Word bits 23:18 have no effect on any output.
- R9: Falling SCLK edges after the 24th in the same SYNC-low window are ignored. They cause no second pulse and no change to the outputs.
- R10: Each new SYNC-low window starts counting from bit 23, so a full word after an aborted one commits correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sync_ni | input | 1 | Active-low frame select, asynchronous |
| din_i | input | 1 | Serial data, asynchronous |
| dac_code_o | output | 16 | Stored DAC code |
| out_en_o | output | 1 | Output amplifier enable (mode 00) |
| pd_1k_o | output | 1 | 1k pull-down select (mode 01) |
| pd_100k_o | output | 1 | 100k pull-down select (mode 10) |
| updated_o | output | 1 | Single-cycle pulse on each commit |

## Verification
The in-line assertions check several rules on every cycle. The strobes never conflict. The bit count never passes 24. A commit pulse lasts one cycle and only arises inside a select-low window. The code and mode registers change only in a commit cycle, and a power-down commit never moves the code. Only the bench's scenarios can show the serial behaviour itself. The bench shows that bit order and field placement map correctly to the outputs, and that the don't-care bits are masked. It shows that an aborted word leaves no trace, that surplus edges are discarded, and that counting restarts cleanly after an abort.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PD_1K  = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_HIZ    = 2'b11
  } pd_mode_e;

  localparam int unsigned FRAME_W  = 24;
  localparam int unsigned CODE_W   = 16;
  localparam int unsigned MODE_LSB = 16;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               din_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic             sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic             done_q;
  logic             fall;

  assign fall = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      done_q <= 1'b0;
      if (sync_ni) begin
        cnt_q <= '0;  // idle or abort: next window restarts at bit 0
      end else if (fall && cnt_q != CNT_FULL) begin
        sr_q  <= {sr_q[FRAME_W-2:0], din_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) done_q <= 1'b1;
      end
    end
  end

  assign frame_o = sr_q;
  assign done_o  = done_q;

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(!sync_ni));
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int unsigned FRAME_W  = 24,
  parameter int unsigned CODE_W   = 16,
  parameter int unsigned MODE_LSB = 16,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               commit_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               out_en_o,
  output logic               pd_1k_o,
  output logic               pd_100k_o,
  output logic               updated_o
);
  logic [CODE_W-1:0] code_q;
  pd_mode_e          mode_q;
  pd_mode_e          mode_in;
  logic              upd_q;

  assign mode_in = pd_mode_e'(frame_i[MODE_LSB+1:MODE_LSB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RESET_CODE;
      mode_q <= MODE_NORMAL;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit_i;
      if (commit_i) begin
        mode_q <= mode_in;
        // power-down words keep the stored code
        if (mode_in == MODE_NORMAL) code_q <= frame_i[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    out_en_o  = 1'b0;
    pd_1k_o   = 1'b0;
    pd_100k_o = 1'b0;
    unique case (mode_q)
      MODE_NORMAL:  out_en_o  = 1'b1;
      MODE_PD_1K:   pd_1k_o   = 1'b1;
      MODE_PD_100K: pd_100k_o = 1'b1;
      default: ;
    endcase
  end

  assign code_o    = code_q;
  assign updated_o = upd_q;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_en_o, pd_1k_o, pd_100k_o}));
  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(code_q) && $stable(mode_q));
  p_code_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && mode_in != MODE_NORMAL) |=> $stable(code_q));
  p_upd_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> updated_o);
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
  import sdac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              din_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              out_en_o,
  output logic              pd_1k_o,
  output logic              pd_100k_o,
  output logic              updated_o
);
  logic [2:0]         link_s;
  logic [FRAME_W-1:0] frame;
  logic               done;

  sdac_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({din_i, sync_ni, sclk_i}),
    .q_o   (link_s)
  );

  sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (link_s[0]),
    .sync_ni(link_s[1]),
    .din_i  (link_s[2]),
    .frame_o(frame),
    .done_o (done)
  );

  sdac_regs #(
    .FRAME_W   (FRAME_W),
    .CODE_W    (CODE_W),
    .MODE_LSB  (MODE_LSB),
    .RESET_CODE(RESET_CODE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame),
    .commit_i (done),
    .code_o   (dac_code_o),
    .out_en_o (out_en_o),
    .pd_1k_o  (pd_1k_o),
    .pd_100k_o(pd_100k_o),
    .updated_o(updated_o)
  );
endmodule

// File: tb/sdac_rx_tb.sv
module sdac_rx_tb_top;
  localparam logic [15:0] RST_CODE = 16'h8000;
  localparam int NV = 8;
  localparam logic [23:0] FR    [NV] = '{24'hFC1234, 24'h00ABCD, 24'h01FFFF, 24'h020000,
                                         24'h035555, 24'h00FFFF, 24'hA80001, 24'h008000};
  localparam logic [15:0] EXP_C [NV] = '{16'h1234, 16'hABCD, 16'hABCD, 16'hABCD,
                                         16'hABCD, 16'hFFFF, 16'h0001, 16'h8000};
  localparam logic [1:0]  EXP_M [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b1, sync_ni = 1'b1, din_i = 1'b0;
  logic [15:0] dac_code_o;
  logic out_en_o, pd_1k_o, pd_100k_o, updated_o;
  int checks = 0, fails = 0, upd_cnt = 0;

  always #5 clk_i = ~clk_i;

  sdac_rx #(.RESET_CODE(RST_CODE)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sync_ni(sync_ni), .din_i(din_i),
    .dac_code_o(dac_code_o), .out_en_o(out_en_o), .pd_1k_o(pd_1k_o),
    .pd_100k_o(pd_100k_o), .updated_o(updated_o));

  always @(negedge clk_i) if (updated_o) upd_cnt++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bits sent MSB first; extra edges carry inverted data
  task automatic send(input logic [23:0] w, input int nbits, input int extra);
    wait_clk(1);
    sync_ni = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits + extra; i++) begin
      din_i = (i < nbits) ? w[23-i] : ~w[0];
      wait_clk(4);
      sclk_i = 1'b0;
      wait_clk(4);
      sclk_i = 1'b1;
    end
    wait_clk(4);
    sync_ni = 1'b1;
    wait_clk(10);
  endtask

  function automatic logic [2:0] strobes(input logic [1:0] m);
    return {m == 2'd0, m == 2'd1, m == 2'd2};
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int u0;
    wait_clk(3);
    // R7 reset state
    check("R7 code", 32'(dac_code_o), 32'(RST_CODE));
    check("R7 strobes", 32'({out_en_o, pd_1k_o, pd_100k_o}), 32'(3'b100));
    rst_ni = 1'b1;
    wait_clk(20);
    check("R7 hold", 32'(dac_code_o), 32'(RST_CODE));
    check("R7 no pulse", 32'(upd_cnt), 32'd0);

    // table: R1 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      u0 = upd_cnt;
      send(FR[v], 24, 0);
      check("R1/R6/R8 code", 32'(dac_code_o), 32'(EXP_C[v]));
      check("R4/R5 strobes", 32'({out_en_o, pd_1k_o, pd_100k_o}), 32'(strobes(EXP_M[v])));
      check("R2 one pulse", 32'(upd_cnt - u0), 32'd1);
    end

    // R3 abort after 23 bits, word would set pd_1k and code
    u0 = upd_cnt;
    send(24'h01BEEF, 23, 0);
    check("R3 code", 32'(dac_code_o), 32'h8000);
    check("R3 strobes", 32'({out_en_o, pd_1k_o, pd_100k_o}), 32'(3'b100));
    check("R3 no pulse", 32'(upd_cnt - u0), 32'd0);

    // R10 short abort then full word
    send(24'h00FFFF, 10, 0);
    u0 = upd_cnt;
    send(24'h003C5A, 24, 0);
    check("R10 code", 32'(dac_code_o), 32'h3C5A);
    check("R10 pulse", 32'(upd_cnt - u0), 32'd1);

    // R9 surplus edges after 24th
    u0 = upd_cnt;
    send(24'h00A5A5, 24, 5);
    check("R9 code", 32'(dac_code_o), 32'hA5A5);
    check("R9 strobes", 32'({out_en_o, pd_1k_o, pd_100k_o}), 32'(3'b100));
    check("R9 single pulse", 32'(upd_cnt - u0), 32'd1);

    // R6 hi-z then back to normal with new code
    send(24'h031111, 24, 0);
    check("R6 code kept", 32'(dac_code_o), 32'hA5A5);
    check("R4 hiz", 32'({out_en_o, pd_1k_o, pd_100k_o}), 32'(3'b000));
    send(24'h000042, 24, 0);
    check("R4 normal", 32'({out_en_o, pd_1k_o, pd_100k_o}), 32'(3'b100));
    check("R1 code", 32'(dac_code_o), 32'h0042);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule